// File: doc/BRIEF.md
# Burst DMA Bus Master Sequencer

This block is the control sequencer that lets a DMA engine take over a multiplexed address/data processor bus and move 32-bit words between a FIFO and memory. It watches a FIFO status flag as its transfer request. It asks the bus owner for the bus with a hold/acknowledge handshake. Once it has the bus, it runs bursts made of one address phase followed by up to four data phases. It never touches data itself. It drives the bus control lines and pulses update strobes for the external address and byte-count registers.

The first data phase of a burst is chosen from the remaining byte count. This means every burst, and so every transfer, finishes in the same fourth data-phase state, the only one that flags the last beat. When a burst completes, the block either starts another address phase or returns the bus.

Top module: `dma_burst_master`

## Requirements
- R1: During and directly after reset the block is idle: `hold_req`=0, `ads_n`=1, `blast_n`=1, `be_n`=4'hF, `ad_oe`=0, `addr_inc`=0 and `cnt_dec`=0.
- R2: The request is `!rd_empty` when `dir`=1 and `!wr_full` when `dir`=0. The flag of the other direction has no effect.
- R3: While `xfer_count` is zero, a request leaves the block idle with `hold_req` low.
- R4: A valid request raises `hold_req` on the next clock. No address phase starts until `hold_ack` has been seen high.
- R5: `ctl_oe`, the enable for the strobe, last, select and byte-enable drivers, equals `hold_ack` at all times.
- R6: The address phase lasts exactly one clock. In it `ads_n`=0, `ad_oe`=1 and `ad_out` carries `xfer_addr`. `ad_out` is zero outside it.
- R7: From the address phase, a count of 16 or more bytes gives a four-beat burst. Counts of 12, 8 and 4 bytes give three, two and one beats. A transfer of N bytes therefore uses ceil(N/16) address phases and N/4 beats, and ends with the count at zero.
- R8: `blast_n` is low only in the fourth data-phase state, so it marks exactly the final beat of each burst.
- R9: A data phase holds while `rdy_n` is high. When `rdy_n` is low, `addr_inc` and `cnt_dec` pulse together for that cycle only (address +4, count -4 outside the block).
- R10: `be_n` is 4'h0 in every data phase and 4'hF in every other state.
- R11: After the final beat of a burst the block goes back to the address phase if more than 4 bytes were left before that beat and the request still holds. Otherwise it drops `hold_req` and goes idle.
- R12: `wr_sel` equals `dir`, so 1 means the block writes to the bus. In data phases `ad_oe` equals `dir`. Read and write sequences are otherwise identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low synchronous reset |
| dir | input | 1 | 1: FIFO data written to bus, 0: bus data read into FIFO |
| rd_empty | input | 1 | outbound FIFO empty flag |
| wr_full | input | 1 | inbound FIFO full flag |
| xfer_addr | input | 32 | current transfer address register |
| xfer_count | input | 16 | remaining byte count register |
| hold_ack | input | 1 | bus grant from the bus owner |
| rdy_n | input | 1 | active-low ready from the addressed device |
| hold_req | output | 1 | bus request |
| ads_n | output | 1 | active-low address strobe |
| blast_n | output | 1 | active-low last beat of burst |
| wr_sel | output | 1 | write/read select, 1 = write |
| be_n | output | 4 | active-low byte enables |
| ctl_oe | output | 1 | output enable for the control drivers |
| ad_oe | output | 1 | output enable for the address/data lines |
| ad_out | output | 32 | address value driven during the address phase |
| addr_inc | output | 1 | strobe: advance address by 4 |
| cnt_dec | output | 1 | strobe: reduce count by 4 |

## Verification
The assertions assume several things about the environment. `hold_ack` is returned only while `hold_req` is high, and it stays high until the block releases the bus. `xfer_count` is a multiple of 4. The external address and count registers take the strobes at the next clock edge. The bench keeps to these rules with a small bus-owner model that echoes `hold_req` one clock later as `hold_ack`, and with count and address registers that it updates only from the strobes. Every programmed count is a multiple of 4.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_ADDR, ST_D1, ST_D2, ST_D3, ST_D4
  } seq_state_t;

  localparam int BEAT_BYTES  = 4;
  localparam int BURST_BEATS = 4;
  localparam int BURST_BYTES = BEAT_BYTES * BURST_BEATS;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel (
  input  logic dir,
  input  logic rd_empty,
  input  logic wr_full,
  output logic req
);
  always_comb begin
    if (dir) req = !rd_empty;
    else     req = !wr_full;
  end
endmodule

// File: rtl/dma_entry_dec.sv
module dma_entry_dec
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  output seq_state_t       entry
);
  localparam logic [CNT_W-1:0] FULL_B  = CNT_W'(BURST_BYTES);
  localparam logic [CNT_W-1:0] THREE_B = CNT_W'(3 * BEAT_BYTES);
  localparam logic [CNT_W-1:0] TWO_B   = CNT_W'(2 * BEAT_BYTES);

  always_comb begin
    if (count >= FULL_B)       entry = ST_D1;
    else if (count == THREE_B) entry = ST_D2;
    else if (count == TWO_B)   entry = ST_D3;
    else                       entry = ST_D4;
  end
endmodule

// File: rtl/dma_out_dec.sv
module dma_out_dec
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  seq_state_t        cur,
  input  logic              dir,
  input  logic              rdy_n,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic              hold_req,
  output logic              ads_n,
  output logic              blast_n,
  output logic [BE_W-1:0]   be_n,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic              beat_done
);
  logic in_addr;
  logic in_data;

  always_comb begin
    in_addr   = (cur == ST_ADDR);
    in_data   = (cur == ST_D1) || (cur == ST_D2) ||
                (cur == ST_D3) || (cur == ST_D4);
    hold_req  = (cur != ST_IDLE);
    ads_n     = !in_addr;
    blast_n   = (cur != ST_D4);
    be_n      = in_data ? '0 : '1;
    ad_oe     = in_addr || (in_data && dir);
    ad_out    = in_addr ? xfer_addr : '0;
    beat_done = in_data && !rdy_n;
  end
endmodule

// File: rtl/dma_burst_master.sv
module dma_burst_master
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              rd_empty,
  input  logic              wr_full,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic              hold_ack,
  input  logic              rdy_n,
  output logic              hold_req,
  output logic              ads_n,
  output logic              blast_n,
  output logic              wr_sel,
  output logic [BE_W-1:0]   be_n,
  output logic              ctl_oe,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic              addr_inc,
  output logic              cnt_dec
);
  localparam logic [CNT_W-1:0] ONE_BEAT = CNT_W'(BEAT_BYTES);

  seq_state_t cur, nxt, entry;
  logic       req;
  logic       cnt_nz;
  logic       more_left;
  logic       beat_done;

  dma_req_sel u_req (
    .dir      (dir),
    .rd_empty (rd_empty),
    .wr_full  (wr_full),
    .req      (req)
  );

  dma_entry_dec #(.CNT_W(CNT_W)) u_entry (
    .count (xfer_count),
    .entry (entry)
  );

  dma_out_dec #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_out (
    .cur       (cur),
    .dir       (dir),
    .rdy_n     (rdy_n),
    .xfer_addr (xfer_addr),
    .hold_req  (hold_req),
    .ads_n     (ads_n),
    .blast_n   (blast_n),
    .be_n      (be_n),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .beat_done (beat_done)
  );

  assign cnt_nz    = (xfer_count != '0);
  assign more_left = (xfer_count > ONE_BEAT);

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: if (req && cnt_nz) nxt = ST_HOLD;
      ST_HOLD: if (hold_ack)      nxt = ST_ADDR;
      ST_ADDR:                    nxt = entry;
      ST_D1:   if (!rdy_n)        nxt = ST_D2;
      ST_D2:   if (!rdy_n)        nxt = ST_D3;
      ST_D3:   if (!rdy_n)        nxt = ST_D4;
      ST_D4:   if (!rdy_n)        nxt = (more_left && req) ? ST_ADDR : ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_IDLE;
    else        cur <= nxt;
  end

  assign wr_sel   = dir;
  assign ctl_oe   = hold_ack;
  assign addr_inc = beat_done;
  assign cnt_dec  = beat_done;
endmodule

// File: rtl/dma_burst_master_chk.sv
module dma_burst_master_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int BE_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] xfer_count,
  input logic             rdy_n,
  input logic             hold_req,
  input logic             ads_n,
  input logic             blast_n,
  input logic [BE_W-1:0]  be_n,
  input logic             ad_oe,
  input logic             addr_inc,
  input logic             cnt_dec
);
  // R3
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req && xfer_count == '0) |=> !hold_req);

  // R6
  addr_phase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  // R6
  addr_phase_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |-> (ad_oe && hold_req && be_n == '1));

  // R8
  last_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blast_n |-> be_n == '0);

  // R8
  last_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && !rdy_n) |=> blast_n);

  // R9
  update_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc || cnt_dec) |-> (be_n == '0 && !rdy_n && addr_inc && cnt_dec));

  // R9
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be_n == '0 && rdy_n) |=> be_n == '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |-> (be_n == '1 && ads_n && blast_n));
endmodule

bind dma_burst_master dma_burst_master_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BE_W(BE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_count (xfer_count),
  .rdy_n      (rdy_n),
  .hold_req   (hold_req),
  .ads_n      (ads_n),
  .blast_n    (blast_n),
  .be_n       (be_n),
  .ad_oe      (ad_oe),
  .addr_inc   (addr_inc),
  .cnt_dec    (cnt_dec)
);

// File: tb/dma_burst_master_tb.sv
`timescale 1ns/100ps
module dma_burst_master_tb;
  typedef struct packed {
    logic        d;
    logic [15:0] cnt;
    logic [3:0]  rper;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd4,  4'd1},
    '{1'b0, 16'd8,  4'd1},
    '{1'b1, 16'd12, 4'd2},
    '{1'b0, 16'd16, 4'd1},
    '{1'b1, 16'd20, 4'd3},
    '{1'b0, 16'd44, 4'd1},
    '{1'b1, 16'd64, 4'd2},
    '{1'b0, 16'd28, 4'd1}
  };
  localparam logic [31:0] BASE = 32'h0001_0F00;

  logic        clk = 0, rst_n = 0;
  logic        dir = 0, rd_empty = 1, wr_full = 1, hold_ack = 0, rdy_n = 1;
  logic [31:0] m_addr = BASE;
  logic [15:0] m_cnt = 0;
  logic        hold_req, ads_n, blast_n, wr_sel, ctl_oe, ad_oe, addr_inc, cnt_dec;
  logic [3:0]  be_n;
  logic [31:0] ad_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit ack_en = 1, rdy_hi = 0;
  int rdy_per = 1, cyc = 0;
  logic s_hold = 0, p_upd = 0;
  int n_ads, n_beat, n_blast, bad_ad, bad_upd, bad_wr, bad_oe, bad_blast;

  always #2.5 clk = ~clk;

  dma_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .dir(dir), .rd_empty(rd_empty), .wr_full(wr_full),
    .xfer_addr(m_addr), .xfer_count(m_cnt), .hold_ack(hold_ack), .rdy_n(rdy_n),
    .hold_req(hold_req), .ads_n(ads_n), .blast_n(blast_n), .wr_sel(wr_sel),
    .be_n(be_n), .ctl_oe(ctl_oe), .ad_oe(ad_oe), .ad_out(ad_out),
    .addr_inc(addr_inc), .cnt_dec(cnt_dec)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    n_ads = 0; n_beat = 0; n_blast = 0; bad_ad = 0;
    bad_upd = 0; bad_wr = 0; bad_oe = 0; bad_blast = 0;
  endtask

  // one clock: registers outside the block update from last strobes, then sample
  task automatic step();
    bit beat;
    @(posedge clk); #1;
    if (p_upd) begin
      m_cnt  = m_cnt - 16'd4;
      m_addr = m_addr + 32'd4;
    end
    hold_ack = ack_en & s_hold;
    cyc++;
    rdy_n = rdy_hi || (rdy_per == 0) || ((cyc % rdy_per) != 0);
    #1;
    s_hold = hold_req;
    p_upd  = cnt_dec;
    beat   = (be_n == 4'h0) && !rdy_n;
    if (!ads_n) begin
      n_ads++;
      if (ad_out !== m_addr) bad_ad++;
    end
    if (beat) begin
      n_beat++;
      if (!blast_n) n_blast++;
    end
    if (addr_inc !== beat || cnt_dec !== beat) bad_upd++;
    if (be_n == 4'h0 && wr_sel !== dir) bad_wr++;
    if (be_n == 4'h0 && ad_oe !== dir) bad_oe++;
    if (!blast_n && be_n != 4'h0) bad_blast++;
  endtask

  task automatic set_req(input logic d, input bit on);
    dir = d;
    rd_empty = !(on && d);
    wr_full  = !(on && !d);
  endtask

  task automatic run_to_idle(input int drop_at);
    bit seen = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (hold_req) seen = 1;
      if (drop_at > 0 && n_beat >= drop_at) set_req(dir, 0);
      if (seen && !hold_req) break;
    end
    set_req(dir, 0);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    chk(!hold_req && ads_n && blast_n && be_n == 4'hF && !ad_oe && !addr_inc && !cnt_dec,
        "R1 outputs in reset", {hold_req, ads_n, blast_n, be_n}, 7'b0111111);
    @(posedge clk); #1; rst_n = 1;
    step();
    chk(!hold_req && be_n == 4'hF, "R1 idle after reset", hold_req, 0);

    // vector table: R6 R7 R8 R9 R12
    for (int v = 0; v < NV; v++) begin
      int cnt, exp_b;
      cnt = int'(VECS[v].cnt);
      exp_b = (cnt + 15) / 16;
      m_cnt = VECS[v].cnt; m_addr = BASE + 32'(v * 256);
      rdy_per = int'(VECS[v].rper);
      clr_stats();
      set_req(VECS[v].d, 1);
      run_to_idle(0);
      chk(n_beat == cnt / 4, "R7 beats per transfer", n_beat, cnt / 4);
      chk(n_ads == exp_b, "R7 address phases", n_ads, exp_b);
      chk(n_blast == exp_b && bad_blast == 0, "R8 last-beat marks", n_blast, exp_b);
      chk(m_cnt == 0, "R7 count ends at zero", m_cnt, 0);
      chk(m_addr == BASE + 32'(v * 256 + cnt), "R9 address advance", m_addr, BASE + v * 256 + cnt);
      chk(bad_upd == 0, "R9 strobes only on ready beats", bad_upd, 0);
      chk(bad_ad == 0, "R6 address on ad_out", bad_ad, 0);
      chk(bad_wr == 0 && bad_oe == 0, "R12 select and data enable follow dir", bad_wr + bad_oe, 0);
    end
    rdy_per = 1;

    // R3 zero count ignored
    m_cnt = 0; set_req(1, 1);
    repeat (5) step();
    chk(!hold_req, "R3 zero count ignored", hold_req, 0);
    set_req(1, 0);

    // R2 the flag of the other direction has no effect
    m_cnt = 16'd8; dir = 1; rd_empty = 1; wr_full = 0;
    repeat (4) step();
    chk(!hold_req, "R2 dir=1 ignores wr_full", hold_req, 0);
    dir = 0; rd_empty = 0; wr_full = 1;
    repeat (4) step();
    chk(!hold_req, "R2 dir=0 ignores rd_empty", hold_req, 0);

    // R4 R5 wait for grant
    ack_en = 0; m_addr = BASE; set_req(0, 1);
    clr_stats();
    step();
    chk(hold_req, "R4 hold raised one clock after request", hold_req, 1);
    repeat (5) step();
    chk(hold_req && ads_n && n_ads == 0, "R4 no address phase before grant", n_ads, 0);
    chk(!ctl_oe, "R5 drivers off without grant", ctl_oe, 0);
    ack_en = 1;
    step();
    chk(ctl_oe && ads_n, "R5 drivers on with grant", ctl_oe, 1);
    step();
    chk(!ads_n, "R4 address phase after grant", ads_n, 0);
    run_to_idle(0);
    chk(m_cnt == 0 && n_beat == 2, "R4 transfer after grant", n_beat, 2);

    // R9 R10 stall in data phase
    m_cnt = 16'd16; m_addr = BASE; rdy_hi = 1; set_req(1, 1);
    for (int i = 0; i < 20 && be_n != 4'h0; i++) step();
    repeat (4) step();
    chk(m_cnt == 16 && !addr_inc, "R9 no update while not ready", m_cnt, 16);
    chk(be_n == 4'h0 && blast_n, "R10 byte enables held in stalled phase", be_n, 0);
    rdy_hi = 0;
    clr_stats();
    run_to_idle(0);
    chk(m_cnt == 0 && n_beat == 4, "R9 resumes after ready", n_beat, 4);

    // R11 request withdrawn during first burst
    m_cnt = 16'd32; m_addr = BASE; clr_stats(); set_req(0, 1);
    run_to_idle(1);
    chk(m_cnt == 16 && n_ads == 1, "R11 bus released when request drops", m_cnt, 16);
    repeat (4) step();
    chk(!hold_req && be_n == 4'hF, "R11 idle with count left", hold_req, 0);

    // R11 back-to-back bursts keep the bus
    m_cnt = 16'd36; m_addr = BASE; clr_stats(); set_req(1, 1);
    run_to_idle(0);
    chk(n_ads == 3 && m_cnt == 0, "R11 re-enters address phase", n_ads, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule